// File: doc/BRIEF.md
# Credit-Counter Task Arbiter

This block sits beside one processor and decides which of up to eight task slots runs next. Each slot has a credit register, loaded by an external admission controller, and a down-counter. The counter holds how many more times the slot may run in the current replenishment interval. When the processor asks for work, the arbiter grants a slot that is active, ready and still has count left. It moves among such slots in round-robin order. It holds the grant until the processor reports completion, and then takes one from that slot's counter.

An interval has no fixed length. It ends as soon as no active slot has any count left. That can happen because every slot used up its credits, or because the slots that still had count were switched off by zeroing their credit registers. At the end of an interval the arbiter spends one cycle reloading every counter from its credit register and pulses a restart output.

The controller is a three-state machine:
- `ST_IDLE` waits for a request.
- `ST_GRANT` holds a grant until `done`.
- `ST_RELOAD` is the one-cycle refill.

It has four transitions:
- `ST_IDLE` → `ST_GRANT` (*dispatch*): a request arrives and an eligible slot exists.
- `ST_IDLE` → `ST_RELOAD` (*interval end*): a request arrives, at least one slot is active, and no active slot has count left.
- `ST_GRANT` → `ST_IDLE` (*complete*): `done` is seen.
- `ST_RELOAD` → `ST_IDLE` (*refilled*): always, after one cycle.

Top module: `credit_task_arbiter`

## Requirements
- R1: After reset, `gnt_valid` and `restart` are 0, `gnt_idx` is 0, every counter and credit register is 0, and the round-robin search starts at slot 0.
- R2: A cycle with `cred_wr` high stores `cred_val` into the credit register of slot `cred_idx`. The slot's counter does not change until the next reload, so a credit written mid-interval only takes effect in the next interval.
- R3: A slot whose credit register is 0 is inactive and is never granted.
- R4: In `ST_IDLE` with `req` high and an eligible slot present, `gnt_valid` rises after the next clock edge. While it is high, `gnt_idx` stays constant until a cycle with `done` high, after which `gnt_valid` falls.
- R5: `done` during a grant decrements the granted slot's counter by one. Each active slot is therefore granted exactly its credit count per interval.
- R6: The eligible slot chosen is the first one found by scanning upward, with wrap-around, from the slot after the most recently granted one.
- R7: A slot with its `ready` bit low is skipped. If active slots have count left but none is ready, `gnt_valid` stays low and no restart happens.
- R8: On `req` in `ST_IDLE`, when at least one slot is active and no active slot has count left, `restart` is high for exactly one cycle. On that cycle all counters reload from their credit registers, and grants then continue from the round-robin position.
- R9: Writing 0 to the credit register of every slot that still has count ends the interval early, with a restart, before the full credit total has been granted.
- R10: With no active slot at all, a request produces neither a grant nor a restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Processor asks for the next task |
| done | input | 1 | Granted task has finished one execution |
| ready | input | N_SLOTS | Per-slot task-ready flags |
| cred_wr | input | 1 | Credit register write strobe |
| cred_idx | input | IDX_W | Slot addressed by the credit write |
| cred_val | input | CRED_W | Credit value to store |
| gnt_valid | output | 1 | A grant is being held |
| gnt_idx | output | IDX_W | Slot currently granted |
| restart | output | 1 | One-cycle pulse on interval reload |

## Verification
The bench probes the following corners, each against the fault it would expose.

- **Mid-interval credit write.** The test checks that the next grant goes to the other slot. A design that loaded the counter on write would grant the rewritten slot again in the same interval.
- **Non-ready slot with count left.** The test expects the arbiter to stall silently. A design that treated "nothing ready" as "nothing left" would emit a spurious restart and reload counters mid-interval.
- **Slot switched off mid-interval.** A design that only counted down to the credit total would never end such an interval early, because it would wait for count that will never be used.
- **Round robin after a reload.** The bench checks the first grant of each new interval to confirm the pointer survives the refill. A design that reset the pointer on reload would favour slot 0.

// File: rtl/cta_pkg.sv
package cta_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_GRANT  = 2'd1,
        ST_RELOAD = 2'd2
    } arb_state_t;

endpackage

// File: rtl/cta_slot.sv
module cta_slot #(
    parameter int CRED_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CRED_W-1:0] wval,
    input  logic              reload,
    input  logic              dec,
    input  logic              rdy,
    output logic [CRED_W-1:0] credit_o,
    output logic [CRED_W-1:0] count_o,
    output logic              active_o,
    output logic              pending_o,
    output logic              eligible_o
);

    logic [CRED_W-1:0] cred_q;
    logic [CRED_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cred_q <= '0;
        end else if (we) begin
            cred_q <= wval;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (reload) begin
            cnt_q <= cred_q;
        end else if (dec) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        active_o   = (cred_q != '0);
        pending_o  = active_o && (cnt_q != '0);
        eligible_o = pending_o && rdy;
        credit_o   = cred_q;
        count_o    = cnt_q;
    end

    // R5: a completion never decrements an empty counter
    a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (cnt_q != '0));

    // R2: a credit write alone leaves the counter untouched
    a_r2_write_deferred: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !reload && !dec) |=> $stable(cnt_q));

    // R8: reload copies the credit register seen on the reload cycle
    a_r8_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (cnt_q == $past(cred_q)));

endmodule

// File: rtl/cta_rr_pick.sv
module cta_rr_pick #(
    parameter int N_SLOTS = 8,
    parameter int IDX_W   = $clog2(N_SLOTS)
) (
    input  logic [N_SLOTS-1:0] elig,
    input  logic [IDX_W-1:0]   last,
    output logic               found,
    output logic [IDX_W-1:0]   pick
);

    always_comb begin
        found = 1'b0;
        pick  = '0;
        // scan far to near so the nearest hit after 'last' is kept
        for (int k = N_SLOTS; k >= 1; k--) begin
            int j;
            j = (int'(last) + k) % N_SLOTS;
            if (elig[j]) begin
                found = 1'b1;
                pick  = IDX_W'(j);
            end
        end
    end

endmodule

// File: rtl/credit_task_arbiter.sv
module credit_task_arbiter
    import cta_pkg::*;
#(
    parameter int N_SLOTS = 8,
    parameter int CRED_W  = 8,
    parameter int IDX_W   = $clog2(N_SLOTS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic               done,
    input  logic [N_SLOTS-1:0] ready,
    input  logic               cred_wr,
    input  logic [IDX_W-1:0]   cred_idx,
    input  logic [CRED_W-1:0]  cred_val,
    output logic               gnt_valid,
    output logic [IDX_W-1:0]   gnt_idx,
    output logic               restart
);

    localparam logic [IDX_W-1:0] LAST_INIT = IDX_W'(N_SLOTS - 1);

    arb_state_t state_q, state_d;
    logic [IDX_W-1:0] cur_q;
    logic [IDX_W-1:0] last_q;

    logic [N_SLOTS-1:0] act_v, pend_v, elig_v;
    logic [CRED_W-1:0]  cred_w [N_SLOTS];
    logic [CRED_W-1:0]  cnt_w  [N_SLOTS];

    logic               any_active, any_pending, found;
    logic [IDX_W-1:0]   pick;
    logic               do_reload;

    assign do_reload = (state_q == ST_RELOAD);

    for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
        cta_slot #(.CRED_W(CRED_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .we        (cred_wr && (cred_idx == IDX_W'(i))),
            .wval      (cred_val),
            .reload    (do_reload),
            .dec       ((state_q == ST_GRANT) && done && (cur_q == IDX_W'(i))),
            .rdy       (ready[i]),
            .credit_o  (cred_w[i]),
            .count_o   (cnt_w[i]),
            .active_o  (act_v[i]),
            .pending_o (pend_v[i]),
            .eligible_o(elig_v[i])
        );
    end

    cta_rr_pick #(.N_SLOTS(N_SLOTS), .IDX_W(IDX_W)) u_pick (
        .elig (elig_v),
        .last (last_q),
        .found(found),
        .pick (pick)
    );

    assign any_active  = |act_v;
    assign any_pending = |pend_v;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
            last_q  <= LAST_INIT;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && state_d == ST_GRANT) begin
                cur_q  <= pick;
                last_q <= pick;
            end
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req) begin
                    if (any_active && !any_pending) begin
                        state_d = ST_RELOAD;
                    end else if (found) begin
                        state_d = ST_GRANT;
                    end
                end
            end
            ST_GRANT: begin
                if (done) begin
                    state_d = ST_IDLE;
                end
            end
            ST_RELOAD: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        gnt_valid = (state_q == ST_GRANT);
        gnt_idx   = cur_q;
        restart   = (state_q == ST_RELOAD);
    end

    // R8: restart lasts exactly one cycle
    a_r8_restart_single: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !restart);

    // R4: a grant and its index hold until completion
    a_r4_grant_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && !done) |=> (gnt_valid && $stable(gnt_idx)));

    // R5: a new grant goes to a slot with count left
    a_r5_grant_has_count: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gnt_valid) |-> (cnt_w[gnt_idx] != '0));

    // R4: completion drops the grant
    a_r4_done_release: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && done) |=> !gnt_valid);

    // R10: no active slot means no restart
    a_r10_no_idle_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !any_active) |=> !restart);

endmodule

// File: tb/sim_credit_task_arbiter.sv
module sim_credit_task_arbiter;

    localparam int N  = 8;
    localparam int IW = 3;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req, done, cred_wr;
    logic [N-1:0]  ready;
    logic [IW-1:0] cred_idx;
    logic [CW-1:0] cred_val;
    logic          gnt_valid, restart;
    logic [IW-1:0] gnt_idx;

    int n_chk = 0;
    int n_bad = 0;
    int rs_cnt = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    credit_task_arbiter #(.N_SLOTS(N), .CRED_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .done(done), .ready(ready),
        .cred_wr(cred_wr), .cred_idx(cred_idx), .cred_val(cred_val),
        .gnt_valid(gnt_valid), .gnt_idx(gnt_idx), .restart(restart)
    );

    always @(negedge clk) if (rst_n === 1'b1 && restart === 1'b1) rs_cnt++;

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=<20000 cycles", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk_eq(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; req = 1'b0; done = 1'b0; cred_wr = 1'b0;
        ready = '1; cred_idx = '0; cred_val = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rs_cnt = 0;
    endtask

    task automatic wr_cred(int idx, int val);
        cred_wr = 1'b1; cred_idx = IW'(idx); cred_val = CW'(val);
        @(negedge clk);
        cred_wr = 1'b0;
        @(negedge clk);
    endtask

    // wait for a grant, check its slot, then complete it
    task automatic serve(string tag, int exp);
        int w = 0;
        while (!gnt_valid && w < 20) begin
            @(negedge clk);
            w++;
        end
        chk_eq(tag, gnt_valid ? int'(gnt_idx) : -1, exp);
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
    endtask

    task automatic t_reset_and_empty();
        do_reset();
        chk_eq("R1 gnt_valid after reset", gnt_valid, 0);
        chk_eq("R1 restart after reset", restart, 0);
        chk_eq("R1 gnt_idx after reset", gnt_idx, 0);
        req = 1'b1;
        repeat (6) @(negedge clk);
        chk_eq("R10 no grant without credits", gnt_valid, 0);
        chk_eq("R10 no restart without credits", rs_cnt, 0);
        req = 1'b0;
    endtask

    task automatic t_round_robin();
        do_reset();
        wr_cred(0, 2); wr_cred(1, 1); wr_cred(2, 3);
        req = 1'b1;
        @(negedge clk);
        chk_eq("R8 initial restart pulse", restart, 1);
        @(negedge clk);
        chk_eq("R8 restart single cycle", restart, 0);
        chk_eq("R4 no grant during refill", gnt_valid, 0);
        @(negedge clk);
        chk_eq("R4 grant valid", gnt_valid, 1);
        chk_eq("R1 R6 first grant slot 0", gnt_idx, 0);
        repeat (3) @(negedge clk);
        chk_eq("R4 grant held without done", gnt_valid, 1);
        chk_eq("R4 index held without done", gnt_idx, 0);
        serve("R4 complete first", 0);
        serve("R6 rr 1", 1);
        serve("R6 rr 2", 2);
        serve("R5 rr 0 again", 0);
        serve("R5 slot1 spent skip to 2", 2);
        serve("R5 slot2 third", 2);
        serve("R8 after reload rr from 2 to 0", 0);
        chk_eq("R8 R5 restart after credit total", rs_cnt, 2);
        req = 1'b0;
    endtask

    task automatic t_not_ready();
        do_reset();
        wr_cred(0, 2); wr_cred(1, 2); wr_cred(2, 2);
        ready = 8'b0000_0101;
        req = 1'b1;
        serve("R7 skip 1 grant 0", 0);
        serve("R7 skip 1 grant 2", 2);
        serve("R7 grant 0", 0);
        serve("R7 grant 2", 2);
        repeat (5) @(negedge clk);
        chk_eq("R7 stall with no ready slot", gnt_valid, 0);
        chk_eq("R7 no restart while slot pending", rs_cnt, 1);
        ready = 8'b0000_0111;
        serve("R7 ready slot 1", 1);
        serve("R5 slot 1 second", 1);
        serve("R6 after reload continue at 2", 2);
        chk_eq("R8 restart after all spent", rs_cnt, 2);
        req = 1'b0;
    endtask

    task automatic t_early_end();
        do_reset();
        wr_cred(0, 3); wr_cred(1, 3);
        req = 1'b1;
        serve("R9 grant 0", 0);
        serve("R9 grant 1", 1);
        req = 1'b0;
        wr_cred(1, 0);
        req = 1'b1;
        serve("R3 inactive 1 skipped", 0);
        serve("R3 inactive 1 skipped again", 0);
        serve("R9 reload after early end", 0);
        chk_eq("R9 early interval end", rs_cnt, 2);
        req = 1'b0;
    endtask

    task automatic t_deferred_write();
        do_reset();
        wr_cred(0, 1); wr_cred(1, 1);
        req = 1'b1;
        serve("R2 grant 0", 0);
        req = 1'b0;
        wr_cred(0, 3);
        req = 1'b1;
        serve("R2 new credit deferred", 1);
        serve("R2 new credit after reload", 0);
        chk_eq("R2 restart count", rs_cnt, 2);
        serve("R6 rr to 1", 1);
        serve("R5 slot 0 second", 0);
        serve("R5 slot 0 third", 0);
        serve("R8 next interval slot 1", 1);
        chk_eq("R5 restart after 3+1 grants", rs_cnt, 3);
        req = 1'b0;
    endtask

    initial begin
        t_reset_and_empty();
        t_round_robin();
        t_not_ready();
        t_early_end();
        t_deferred_write();
        summary();
        $finish;
    end

endmodule